// File: doc/BRIEF.md
# Self-Timed Nonvolatile Program Sequencer

This block sits behind the serial command decoder of a small word-organised nonvolatile memory. The decoder hands it complete, decoded commands. The block keeps a volatile write-enable latch, checks a hardware program-enable pin, and carries out word write, word erase, fill-all and erase-all operations on a register-array model of the memory. Each operation starts when chip select falls. It then runs a fixed programming interval, counted in system clock cycles, and needs no further serial activity.

While an operation runs, the block shows busy. When the decoder has chip select high again, the block supplies the status level the decoder places on the serial output: low while busy and high once the operation is finished. Reads go straight to the array at any time. The programming time is the parameter `PROG_CYCLES`.

The controller uses four states:
- `ST_IDLE`: no command is waiting.
- `ST_ARMED`: a gated program command is waiting for chip select to fall.
- `ST_BUSY`: the programming interval is running.
- `ST_BAD`: unused encodings, which fall back to `ST_IDLE`.

Transitions:
- `ST_IDLE`/`ST_ARMED` to `ST_ARMED`: a program command is accepted while the latch is set and the pin is high.
- `ST_IDLE`/`ST_ARMED` to `ST_IDLE`: any other accepted command. It also discards any waiting command.
- `ST_ARMED` to `ST_BUSY`: chip select falls with no command present.
- `ST_BUSY` to `ST_IDLE`: the interval counter expires. The array is updated and `done` pulses.

Command encoding on `cmd_op`:

| Value | Command |
|-------|---------|
| 0 | none |
| 1 | read |
| 2 | write word |
| 3 | erase word |
| 4 | fill all words |
| 5 | erase all words |
| 6 | set enable latch |
| 7 | clear enable latch |

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset the enable latch is clear. Commands 2 to 5 presented while it is clear start no cycle: `busy` stays 0 after chip select falls and the array is unchanged.
- R2: Command 6 sets the enable latch and command 7 clears it, whatever the level of `prog_en`. Once set, the latch stays set until command 7 or reset.
- R3: Commands 2 to 5 are accepted only when `prog_en` is 1 in the cycle in which `cmd_valid` is sampled. Otherwise they start nothing.
- R4: An accepted program command starts its cycle only on a falling edge of `cs`, that is, `cs` sampled 0 at a clock edge after being sampled 1 at the edge before. Nothing else starts a cycle.
- R5: `busy` is 1 for exactly `PROG_CYCLES` clock cycles, beginning with the cycle after the edge that saw `cs` fall. No serial activity is needed during that time.
- R6: Command 2 stores `cmd_data` at `cmd_addr` without a prior erase. The new value becomes visible on `rd_data` in the cycle in which `busy` returns to 0.
- R7: Command 3 sets the word at `cmd_addr` to all ones and leaves every other word unchanged.
- R8: Command 4 stores `cmd_data` in every word. Command 5 sets every word to all ones.
- R9: `rd_data` always shows the word at `rd_addr`, whatever the latch state. During a cycle it shows the value held before that cycle.
- R10: `stat_oe` is 1 when `cs` is 1 and a cycle has been launched since the last accepted command. `stat_level` is 0 while busy and 1 otherwise.
- R11: While busy, `cmd_valid` is ignored for every command, including 6 and 7. The latch, the pending operation and the array are unaffected.
- R12: `done` is a single-cycle pulse in the cycle in which `busy` returns to 0, and it is produced once per cycle.
- R13: Reset sets every word of the array to all ones.
- R14: A chip select fall with no accepted program command waiting starts no cycle. This covers a frame cut short, which the decoder never presents as valid, and a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, synchronous to clk |
| prog_en | input | 1 | Hardware program-enable pin level |
| cmd_valid | input | 1 | One-cycle strobe for a complete decoded command |
| cmd_op | input | 3 | Command code, see the table above |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_data | input | DATA_W | Data word for write and fill-all |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Word at rd_addr |
| busy | output | 1 | Programming interval running |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| stat_oe | output | 1 | Status level should be driven on the serial output |
| stat_level | output | 1 | Status level: 0 busy, 1 ready |

## Verification
Assertions check several rules on every cycle:
- a cycle begins only after a chip select fall seen over two edges;
- the array is written only with the latch set;
- the latch and the interval counter ignore commands while busy;
- `done` never lasts two cycles and always coincides with the end of busy.

Only the bench scenarios can show the remaining behaviour:
- the exact length of the busy window;
- the stored values after write, erase, fill and erase-all;
- the blocking effect of the pin and the latch;
- the old data seen during a cycle;
- the status levels seen with chip select raised mid-cycle.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_ERASE = 3'd3,
        OP_FILL  = 3'd4,
        OP_CLRALL= 3'd5,
        OP_WEN   = 3'd6,
        OP_WDIS  = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2,
        ST_BAD   = 2'd3
    } seq_state_e;

    function automatic logic is_prog_op(input seq_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_FILL)  || (op == OP_CLRALL);
    endfunction

endpackage

// File: rtl/prog_wel.sv
module prog_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic wel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (clr_en) begin
            wel <= 1'b0;
        end else if (set_en) begin
            wel <= 1'b1;
        end
    end

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> wel);

    // R2
    wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !wel);

    // R2
    wel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> (wel == $past(wel)));

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic tc
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tc = run && (cnt_q == '0);

    // R5
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tc && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/prog_array.sv
module prog_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_one,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              hit;

        assign hit = wr_all || (wr_one && (wr_addr == ADDR_W'(i)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (hit) begin
                word_q <= wr_data;
            end
        end

        assign words[i] = word_q;
    end

    assign rd_data = words[rd_addr];

    // R8
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_one && wr_all));

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              prog_en,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              stat_oe,
    output logic              stat_level
);

    seq_state_e        state_q, state_d;
    seq_op_e           op_in;
    seq_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              cs_q;
    logic              cs_fall;
    logic              poll_q;
    logic              done_q;
    logic              wel;
    logic              tc;
    logic              arm, load, commit;
    logic              take_cmd;
    logic              wr_one, wr_all;
    logic [DATA_W-1:0] wr_data;

    assign op_in    = seq_op_e'(cmd_op);
    assign cs_fall  = cs_q && !cs;
    assign take_cmd = cmd_valid && (state_q != ST_BUSY);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        load    = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (is_prog_op(op_in) && wel && prog_en) begin
                        state_d = ST_ARMED;
                        arm     = 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (cmd_valid) begin
                    if (is_prog_op(op_in) && wel && prog_en) begin
                        arm = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (cs_fall) begin
                    state_d = ST_BUSY;
                    load    = 1'b1;
                end
            end
            ST_BUSY: begin
                if (tc) begin
                    state_d = ST_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs;
            if (arm) begin
                op_q   <= op_in;
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            poll_q <= 1'b0;
        end else begin
            done_q <= commit;
            if (load) begin
                poll_q <= 1'b1;
            end else if (take_cmd) begin
                poll_q <= 1'b0;
            end
        end
    end

    assign busy       = (state_q == ST_BUSY);
    assign done       = done_q;
    assign stat_oe    = cs && poll_q;
    assign stat_level = !busy;

    assign wr_one  = commit && ((op_q == OP_WRITE) || (op_q == OP_ERASE));
    assign wr_all  = commit && ((op_q == OP_FILL)  || (op_q == OP_CLRALL));
    assign wr_data = ((op_q == OP_ERASE) || (op_q == OP_CLRALL)) ? '1 : data_q;

    prog_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (take_cmd && (op_in == OP_WEN)),
        .clr_en (take_cmd && (op_in == OP_WDIS)),
        .wel    (wel)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .run   (busy),
        .tc    (tc)
    );

    prog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (addr_q),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R4
    launch_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(cs) && $past(cs, 2)));

    // R1
    write_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_one || wr_all) |-> wel);

    // R11
    busy_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (wel == $past(wel)));

    // R11
    busy_keeps_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> (busy && (op_q == $past(op_q)) && (addr_q == $past(addr_q))));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    status_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stat_level);

endmodule

// File: tb/sim_eeprom_prog_seq.sv
module sim_eeprom_prog_seq;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int P  = 40;
    localparam logic [DW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b1;
    logic          prog_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, done, stat_oe, stat_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    eeprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .prog_en(prog_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .stat_oe(stat_oe), .stat_level(stat_level)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic peek(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    // drop cs, count busy cycles and done pulses, raise cs again
    task automatic fire(input int exp_busy, input string req);
        int nb = 0;
        int nd = 0;
        @(negedge clk);
        cs = 1'b0;
        for (int i = 0; i < P + 8; i++) begin
            @(negedge clk);
            if (busy) nb++;
            if (done) nd++;
        end
        cs = 1'b1;
        check(nb == exp_busy, req, nb, exp_busy);
        check(nd == ((exp_busy > 0) ? 1 : 0), "R12 done count", nd, (exp_busy > 0) ? 1 : 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);
        check(stat_oe == 1'b0, "R10 no status after reset", stat_oe, 0);
        peek(0, ONES, "R13 word0 ones");
        peek(63, ONES, "R13 word63 ones");
    endtask

    task automatic t_locked;
        prog_en = 1'b1;
        send(3'd2, 5, 16'h1234);
        fire(0, "R1 locked write no cycle");
        peek(5, ONES, "R1 word unchanged");
    endtask

    task automatic t_pin;
        prog_en = 1'b0;
        send(3'd6, 0, 0);
        send(3'd2, 5, 16'h1234);
        fire(0, "R3 pin low blocks write");
        peek(5, ONES, "R3 word unchanged");
        prog_en = 1'b1;
        send(3'd2, 5, 16'h1234);
        fire(P, "R5 busy length, R2 enable with pin low");
        peek(5, 16'h1234, "R6 word written");
    endtask

    task automatic t_status_read;
        int guard = 0;
        send(3'd2, 5, 16'hABCD);
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_addr = 5;
        #1;
        check(rd_data == 16'h1234, "R9 old data during cycle", rd_data, 16'h1234);
        cs = 1'b1;
        #1;
        check(stat_oe == 1'b1 && stat_level == 1'b0, "R10 busy status", {stat_oe, stat_level}, 2'b10);
        while (busy && guard < P + 8) begin
            @(negedge clk);
            guard++;
        end
        check(rd_data == 16'hABCD, "R6 visible when busy ends", rd_data, 16'hABCD);
        check(stat_oe == 1'b1 && stat_level == 1'b1, "R10 ready status", {stat_oe, stat_level}, 2'b11);
    endtask

    task automatic t_cut;
        fire(0, "R14 cs fall with nothing pending");
        send(3'd1, 2, 0);
        fire(0, "R14 read does not launch");
        send(3'd2, 4, 16'h7777);
        send(3'd1, 4, 0);
        fire(0, "R14 read discards pending write");
        peek(4, ONES, "R14 word unchanged");
    endtask

    task automatic t_erase;
        send(3'd2, 6, 16'h0F0F);
        fire(P, "R6 second write");
        send(3'd3, 5, 0);
        fire(P, "R7 erase runs");
        peek(5, ONES, "R7 erased word ones");
        peek(6, 16'h0F0F, "R7 neighbour kept");
    endtask

    task automatic t_all;
        send(3'd4, 0, 16'h5A5A);
        fire(P, "R8 fill runs");
        peek(0, 16'h5A5A, "R8 fill word0");
        peek(33, 16'h5A5A, "R8 fill word33");
        peek(63, 16'h5A5A, "R8 fill word63");
        send(3'd5, 0, 0);
        fire(P, "R8 erase-all runs");
        peek(6, ONES, "R8 erase-all word6");
        peek(63, ONES, "R8 erase-all word63");
    endtask

    task automatic t_busy_ignore;
        int guard = 0;
        send(3'd2, 7, 16'h1111);
        @(negedge clk);
        cs = 1'b0;
        @(negedge clk);
        send(3'd7, 0, 0);
        send(3'd2, 8, 16'h2222);
        while ((busy || done) && guard < P + 8) begin
            @(negedge clk);
            guard++;
        end
        cs = 1'b1;
        fire(0, "R11 write sent while busy not launched");
        peek(7, 16'h1111, "R11 first write kept");
        peek(8, ONES, "R11 ignored write absent");
        send(3'd2, 9, 16'h3333);
        fire(P, "R11 latch survived disable sent while busy");
        peek(9, 16'h3333, "R11 later write stored");
    endtask

    task automatic t_disable;
        send(3'd7, 0, 0);
        send(3'd2, 9, 16'h4444);
        fire(0, "R2 disable blocks write");
        peek(9, 16'h3333, "R2 word kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_pin();
        t_status_read();
        t_cut();
        t_erase();
        t_all();
        t_busy_ignore();
        t_disable();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule